// File: doc/BRIEF.md
# SPI Slave to Parallel Bus Bridge

This block is an SPI slave that runs entirely in the system clock domain. It turns each 16-bit SPI frame into one read-then-write access on an internal parallel bus. That bus has a 4-bit address, a 12-bit shared data bus and an active-low write strobe. A frame opens when chip select falls.

The first four bits clocked in (MSB first) name the target. Once they are received, they go onto the address bus, and the addressed target places its 12-bit value on the data bus. The bridge copies that value into its transmit register and returns it on MISO, MSB first. At the same time it collects twelve new bits from MOSI. When all sixteen bits have arrived, the bridge drives the received word onto the data bus during a single-cycle write strobe. It then waits for chip select to go high.

The SPI mode is mode 0: MOSI is taken at SCLK rising edges and MISO changes after falling edges. Chip select, SCLK and MOSI each pass through a two-flop synchronizer before edge detection. For this reason the system clock must run at least four times faster than SCLK. The shared data bus is modelled as separate output, output-enable and input signals.

Top module: `spi_bus_bridge`

## Requirements
- R1: After reset, bus_we_n is 1, bus_wdata_oe is 0, spi_miso is 0 and bus_addr is 0.
- R2: SCLK activity while chip select is high starts no access: no write strobe occurs and MISO stays 0.
- R3: The first four bits of a frame (MSB first) appear on bus_addr once the fourth rising SCLK edge has been seen. They stay unchanged for the rest of the frame.
- R4: The value present on bus_rdata for the selected address is returned on MISO, MSB first. Each bit is valid before the rising SCLK edge of frame bits 5 through 16.
- R5: After the 16th rising SCLK edge, bus_we_n goes low for exactly one system clock cycle while bus_wdata carries frame bits 5..16 (MSB first). There is exactly one strobe per frame.
- R6: bus_wdata_oe is high only in the cycle where bus_we_n is low. At all other times the bridge releases the data bus.
- R7: If chip select rises before 16 bits have been received, no write strobe occurs and the target keeps its value. The next frame then works normally.
- R8: SCLK edges beyond the 16th, before chip select rises, are ignored: no second strobe occurs and the written value is not altered.
- R9: spi_miso is 0 whenever chip select is high.
- R10: Consecutive frames each need chip select to rise and fall again. Each frame addresses its own target independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master, 0 when idle |
| bus_addr | output | 4 | Internal bus address |
| bus_rdata | input | 12 | Value seen on the shared data bus |
| bus_wdata | output | 12 | Value the bridge drives on the data bus |
| bus_wdata_oe | output | 1 | Drive enable for bus_wdata |
| bus_we_n | output | 1 | Write strobe, active low |

## Verification
The bench aims at four corner cases:
- Aborted and overlong frames: a bridge that counted bits loosely would strobe on a short frame, or strobe twice when extra clocks follow bit 16.
- The first returned bit: if the bridge shifted the transmit register on the falling edge right after the address, the master would lose the MSB and see the read data shifted left.
- Writes at address 0 and 15, with all-ones and all-zeros data, and a later read of the same target: these expose bit-order or address-latch slips.
- Width of the strobe and the pairing of drive enable with it: both are watched every cycle, so a strobe stretched past one cycle or a bus driven outside the strobe is caught.

// File: rtl/spi_bus_bridge.sv
module spi_bus_bridge #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wdata_oe,
  output logic              bus_we_n
);
  localparam int FRAME = ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_LOAD, S_DATA, S_WE_LO, S_WE_HI, S_WAIT} state_t;

  state_t             state;
  logic [2:0]         cs_p, sck_p;
  logic [1:0]         mosi_p;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME-1:0]   rx_sr;
  logic [DATA_W-1:0]  tx_sr;
  logic [ADDR_W-1:0]  addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p   <= '1;
      sck_p  <= '0;
      mosi_p <= '0;
    end else begin
      cs_p   <= {cs_p[1:0], spi_cs_n};
      sck_p  <= {sck_p[1:0], spi_sck};
      mosi_p <= {mosi_p[0], spi_mosi};
    end
  end

  wire cs_high  = cs_p[1];
  wire cs_fall  = cs_p[2:1] == 2'b10;
  wire sck_rise = sck_p[2:1] == 2'b01;
  wire sck_fall = sck_p[2:1] == 2'b10;
  wire mosi_bit = mosi_p[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      addr_q  <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (cs_fall) begin
            bit_cnt <= '0;
            state   <= S_ADDR;
          end
        S_ADDR:
          if (cs_high) state <= S_IDLE;
          else if (sck_rise) begin
            rx_sr   <= {rx_sr[FRAME-2:0], mosi_bit};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(ADDR_W - 1)) begin
              addr_q <= {rx_sr[ADDR_W-2:0], mosi_bit};
              state  <= S_LOAD;
            end
          end
        S_LOAD:
          if (cs_high) state <= S_IDLE;
          else begin
            tx_sr <= bus_rdata;
            state <= S_DATA;
          end
        S_DATA:
          if (cs_high) state <= S_IDLE;
          else begin
            if (sck_rise) begin
              rx_sr   <= {rx_sr[FRAME-2:0], mosi_bit};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == CNT_W'(FRAME - 1)) state <= S_WE_LO;
            end
            if (sck_fall && bit_cnt > CNT_W'(ADDR_W))
              tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
          end
        S_WE_LO: state <= S_WE_HI;
        S_WE_HI: state <= S_WAIT;
        S_WAIT:  if (cs_high) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bus_addr     = addr_q;
  assign bus_wdata    = rx_sr[DATA_W-1:0];
  assign bus_wdata_oe = state == S_WE_LO;
  assign bus_we_n     = state != S_WE_LO;
  assign spi_miso     = (state == S_DATA) && tx_sr[DATA_W-1];

  assert_we_pulse_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |=> bus_we_n);
  assert_we_after_full_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_we_n) |-> bit_cnt == CNT_W'(FRAME));
  assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_DATA |-> $stable(bus_addr));
  assert_miso_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> !spi_miso);
  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME));
endmodule

// File: tb/spi_bus_bridge_bench.sv
module spi_bus_bridge_bench;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sck = 0, mosi = 0;
  logic miso, oe, we_n;
  logic [3:0]  addr;
  logic [11:0] wdata, rdata;
  logic [11:0] mem [16];
  int checks = 0, errors = 0, we_cnt = 0, bad_oe = 0, long_we = 0;
  logic we_prev = 1;
  bit done = 0;

  always #2 clk = ~clk;

  spi_bus_bridge u_spi_bus_bridge (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .bus_addr(addr), .bus_rdata(rdata), .bus_wdata(wdata),
    .bus_wdata_oe(oe), .bus_we_n(we_n));

  assign rdata = oe ? wdata : mem[addr];

  always @(posedge clk) begin
    if (!we_n) begin
      we_cnt <= we_cnt + 1;
      if (oe) mem[addr] <= wdata;
    end
    if (oe && we_n) bad_oe <= bad_oe + 1;
    if (!we_n && !we_prev) long_we <= long_we + 1;
    we_prev <= we_n;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [3:0] a, input logic [11:0] wd, input int nbits,
                       output logic [11:0] rd);
    logic [15:0] f = {a, wd};
    rd = '0;
    cs_n = 0;
    wait_clk(6);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? f[15-i] : 1'b1;
      wait_clk(6);
      if (i >= 4 && i < 16) rd[15-i] = miso;
      if (i == 4) check("R3 address latched", addr, a);
      sck = 1;
      wait_clk(6);
      sck = 0;
    end
    wait_clk(6);
    check("R3 address held", addr, a);
    cs_n = 1;
    wait_clk(10);
  endtask

  task automatic t_reset;
    check("R1 we_n", we_n, 1);
    check("R1 oe", oe, 0);
    check("R1 miso", miso, 0);
    check("R1 addr", addr, 0);
  endtask

  task automatic t_idle_sck;
    int w0 = we_cnt;
    for (int i = 0; i < 16; i++) begin
      mosi = i[0];
      wait_clk(6); sck = 1;
      wait_clk(3);
      check("R9 miso while deselected", miso, 0);
      wait_clk(3); sck = 0;
    end
    wait_clk(10);
    check("R2 no strobe while deselected", we_cnt - w0, 0);
  endtask

  task automatic t_rw(input logic [3:0] a, input logic [11:0] wd);
    logic [11:0] rd, old = mem[a];
    int w0 = we_cnt;
    frame(a, wd, 16, rd);
    check("R4 read data on MISO", rd, old);
    check("R5 one strobe", we_cnt - w0, 1);
    check("R5 written value", mem[a], wd);
    check("R9 miso after frame", miso, 0);
  endtask

  task automatic t_abort;
    logic [11:0] rd, old = mem[4'h6];
    int w0 = we_cnt;
    frame(4'h6, 12'h0F0, 10, rd);
    check("R7 no strobe on short frame", we_cnt - w0, 0);
    check("R7 target unchanged", mem[4'h6], old);
    t_rw(4'h6, 12'h9B1);
  endtask

  task automatic t_overrun;
    logic [11:0] rd;
    int w0 = we_cnt;
    frame(4'h3, 12'h5A6, 22, rd);
    check("R8 single strobe with extra clocks", we_cnt - w0, 1);
    check("R8 value from bits 5..16", mem[4'h3], 12'h5A6);
  endtask

  task automatic t_readback;
    logic [11:0] rd;
    frame(4'h9, 12'h000, 16, rd);
    check("R10 second frame reads prior write", rd, 12'h3C7);
    check("R6 bus driven only in strobe", bad_oe, 0);
    check("R5 strobe width one cycle", long_we, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = (12'(i) * 12'h111) ^ 12'h5A5;
    wait_clk(5);
    t_reset;
    rst_n = 1;
    wait_clk(5);
    t_reset;
    t_idle_sck;
    t_rw(4'h9, 12'h3C7);
    t_rw(4'h0, 12'hFFF);
    t_rw(4'hF, 12'h000);
    t_rw(4'hA, 12'h801);
    t_abort;
    t_overrun;
    t_readback;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule